// File: doc/BRIEF.md
# Per-CPU Interrupt Claim Interface

This block sits between a shared interrupt distributor and one processor. It takes a vector of pending interrupt lines aimed at its CPU and holds a per-source enable bit and a per-source in-service bit. It raises a single request line whenever an enabled, pending source is not already in service. The lowest-numbered candidate always wins, and there are no programmable levels or nesting.

Software drives the block through a small register port that has separate read and write channels. Sources are switched on and off by writing their number to a set-enable or a clear-enable address. Reading the claim address hands back the winning number and marks that source as in service, and writing the number to the completion address releases it again. A status address shows whether another candidate is waiting, so a handler can loop until it drains. One more write address sends a software interrupt to a set of other processors. Its payload is a 4-bit interrupt number and an 8-bit target mask, and the block emits it as a one-cycle pulse.

Top module: `cpu_irq_claim_port`

## Requirements
- R1: After reset the interface is off, every enable and in-service bit is clear, `irq_o` is low, `ipi_valid_o` is low, and a status read returns 0x000003FF.
- R2: Bit 0 of address 0x000 switches the interface on and reads back there. While it is 0, `irq_o` stays low, and a claim read returns 0x3FF and changes no state.
- R3: A write of a source number to 0x0A0 sets that source's enable, and a write to 0x0A4 clears it. A written value of NUM_SRC or more is ignored.
- R4: `irq_o` is high in the same cycle whenever the interface is on and some source is pending on `pend_i`, enabled, and not in service.
- R5: A claim read at 0x06C returns, on `reg_rdata` one cycle after the strobe, the lowest-numbered candidate in bits 9:0 with the other bits zero, and marks it in service.
- R6: A claim read with no candidate returns 0x3FF and changes no state.
- R7: A source in service is not presented again until its number is written to 0x0B4. A completion for a source that is not in service has no effect.
- R8: A status read at 0x068 returns bit 31 set with the lowest candidate in bits 9:0 when a candidate exists, and 0x3FF with bit 31 clear otherwise. It has no side effect.
- R9: A write to 0x060 whose bits 15:8 are nonzero pulses `ipi_valid_o` for one cycle, starting at the next clock edge, with `ipi_mask_o` = bits 15:8 and `ipi_id_o` = bits 3:0. A zero mask sends nothing.
- R10: A claim read and a completion write in the same cycle both take effect. The claim is decided on the state before the completion.
- R11: Clearing the enable of the only candidate drops `irq_o` while the line is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_SRC | Pending level per source for this CPU |
| reg_rd | input | 1 | Read strobe |
| reg_raddr | input | 12 | Read byte address |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| reg_wr | input | 1 | Write strobe |
| reg_waddr | input | 12 | Write byte address |
| reg_wdata | input | 32 | Write data |
| irq_o | output | 1 | Interrupt request to the CPU |
| ipi_valid_o | output | 1 | Software interrupt pulse toward other CPUs |
| ipi_mask_o | output | 8 | Target CPU mask of the pulse |
| ipi_id_o | output | 4 | Interrupt number carried by the pulse |

## Verification
A claim read and a completion write can land on the same clock edge because the two channels are independent. The bench claims one source and leaves a second one pending. It then issues a claim read and the completion of the first source together. The read must return the second source, since the first was still in service when the claim was decided. On the following cycles the status must show the first source again, and a fresh claim must return it.

// File: rtl/cpu_irq_claim_port.sv
`timescale 1ns/1ps
module cpu_irq_claim_port #(
  parameter int NUM_SRC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               reg_rd,
  input  logic [11:0]        reg_raddr,
  output logic [31:0]        reg_rdata,
  input  logic               reg_wr,
  input  logic [11:0]        reg_waddr,
  input  logic [31:0]        reg_wdata,
  output logic               irq_o,
  output logic               ipi_valid_o,
  output logic [7:0]         ipi_mask_o,
  output logic [3:0]         ipi_id_o
);
  localparam int ID_W = $clog2(NUM_SRC);
  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_SIG   = 12'h060;
  localparam logic [11:0] A_STAT  = 12'h068;
  localparam logic [11:0] A_CLAIM = 12'h06C;
  localparam logic [11:0] A_SETEN = 12'h0A0;
  localparam logic [11:0] A_CLREN = 12'h0A4;
  localparam logic [11:0] A_DONE  = 12'h0B4;
  localparam logic [9:0]  NO_ID   = 10'h3FF;

  logic               ctrl_en;
  logic [NUM_SRC-1:0] en_q, act_q, cand;
  logic [NUM_SRC-1:0] id_bit, take_bit;
  logic               hit, present, id_ok, take;
  logic [ID_W-1:0]    best, wid;
  logic [9:0]         cur_id;

  assign cand = pend_i & en_q & ~act_q;

  always_comb begin
    hit  = 1'b0;
    best = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit  = 1'b1;
        best = ID_W'(i);
      end
    end
  end

  assign present  = ctrl_en & hit;
  assign irq_o    = present;
  assign cur_id   = present ? 10'(best) : NO_ID;
  assign wid      = reg_wdata[ID_W-1:0];
  assign id_ok    = reg_wdata < 32'(NUM_SRC);
  assign id_bit   = id_ok ? (NUM_SRC'(1) << wid) : '0;
  assign take     = reg_rd && (reg_raddr == A_CLAIM) && present;
  assign take_bit = take ? (NUM_SRC'(1) << best) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      en_q    <= '0;
      act_q   <= '0;
    end else begin
      if (reg_wr && reg_waddr == A_CTRL)
        ctrl_en <= reg_wdata[0];
      if (reg_wr && reg_waddr == A_SETEN)
        en_q <= en_q | id_bit;
      else if (reg_wr && reg_waddr == A_CLREN)
        en_q <= en_q & ~id_bit;
      if (reg_wr && reg_waddr == A_DONE)
        act_q <= (act_q & ~id_bit) | take_bit;
      else
        act_q <= act_q | take_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_raddr)
        A_CTRL:  reg_rdata <= {31'd0, ctrl_en};
        A_STAT:  reg_rdata <= {present, 21'd0, cur_id};
        A_CLAIM: reg_rdata <= {22'd0, cur_id};
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_valid_o <= 1'b0;
      ipi_mask_o  <= '0;
      ipi_id_o    <= '0;
    end else begin
      ipi_valid_o <= reg_wr && reg_waddr == A_SIG && reg_wdata[15:8] != 8'd0;
      if (reg_wr && reg_waddr == A_SIG && reg_wdata[15:8] != 8'd0) begin
        ipi_mask_o <= reg_wdata[15:8];
        ipi_id_o   <= reg_wdata[3:0];
      end
    end
  end
endmodule

module cpu_irq_claim_port_chk #(
  parameter int NUM_SRC = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [11:0]        reg_raddr,
  input logic [31:0]        reg_rdata,
  input logic               reg_wr,
  input logic [11:0]        reg_waddr,
  input logic [31:0]        reg_wdata,
  input logic               irq_o,
  input logic               ipi_valid_o,
  input logic               ctrl_en,
  input logic [NUM_SRC-1:0] act_q
);
  localparam int ID_W = $clog2(NUM_SRC);
  logic [ID_W-1:0] cid;
  logic            claim_rd, done_wr;
  assign cid      = reg_wdata[ID_W-1:0];
  assign claim_rd = reg_rd && reg_raddr == 12'h06C;
  assign done_wr  = reg_wr && reg_waddr == 12'h0B4 && reg_wdata < 32'(NUM_SRC);

  a_r2_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq_o);
  a_r5_claim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && irq_o) |=> reg_rdata < 32'(NUM_SRC));
  a_r6_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !irq_o) |=> reg_rdata == 32'h3FF);
  a_r6_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !irq_o && !reg_wr) |=> $stable(act_q));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && act_q[cid]) |=> !act_q[$past(cid)]);
  a_r9_ipi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid_o |-> $past(reg_wr && reg_waddr == 12'h060 && reg_wdata[15:8] != 8'd0));
endmodule

bind cpu_irq_claim_port cpu_irq_claim_port_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_raddr(reg_raddr),
  .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .ipi_valid_o(ipi_valid_o),
  .ctrl_en(ctrl_en), .act_q(act_q)
);

// File: tb/cpu_irq_claim_port_bench.sv
`timescale 1ns/1ps
module cpu_irq_claim_port_bench;
  localparam int N = 16;
  localparam logic [11:0] A_CTRL = 12'h000, A_SIG = 12'h060, A_STAT = 12'h068,
    A_CLAIM = 12'h06C, A_SETEN = 12'h0A0, A_CLREN = 12'h0A4, A_DONE = 12'h0B4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend = '0;
  logic rd = 0, wr = 0;
  logic [11:0] raddr = '0, waddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, ipi_v;
  logic [7:0] ipi_m;
  logic [3:0] ipi_id;
  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_en = '0, m_act = '0;
  logic m_on = 0;

  always #5 clk = ~clk;

  cpu_irq_claim_port #(.NUM_SRC(N)) u_cpu_irq_claim_port (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .reg_rd(rd), .reg_raddr(raddr),
    .reg_rdata(rdata), .reg_wr(wr), .reg_waddr(waddr), .reg_wdata(wdata),
    .irq_o(irq), .ipi_valid_o(ipi_v), .ipi_mask_o(ipi_m), .ipi_id_o(ipi_id));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [N-1:0] c);
    for (int i = 0; i < N; i++) if (c[i]) return 32'(i);
    return 32'h3FF;
  endfunction

  function automatic logic [N-1:0] cand();
    return m_on ? (pend & m_en & ~m_act) : '0;
  endfunction

  function automatic logic [31:0] exp_stat();
    return (cand() != 0) ? (32'h8000_0000 | lowest(cand())) : 32'h3FF;
  endfunction

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; waddr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; raddr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic claim(input string tag);
    logic [31:0] e, d;
    e = lowest(cand());
    rreg(A_CLAIM, d);
    chk(tag, d, e);
    if (e != 32'h3FF) m_act[e[3:0]] = 1'b1;
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] p, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 ipi after reset", 32'(ipi_v), 0);
    rreg(A_STAT, d); chk("R1 status after reset", d, 32'h3FF);
    rreg(A_CTRL, d); chk("R1 ctrl after reset", d, 0);

    pend = '1;
    for (int i = 0; i < N; i++) begin wreg(A_SETEN, 32'(i)); m_en[i] = 1; end
    chk("R2 irq while off", 32'(irq), 0);
    rreg(A_CLAIM, d); chk("R2 claim while off", d, 32'h3FF);
    wreg(A_CTRL, 1); m_on = 1;
    rreg(A_CTRL, d); chk("R2 ctrl readback", d, 1);
    chk("R2 no state change by off claim", 32'(irq), 1);
    rreg(A_STAT, d); chk("R2 status lowest", d, 32'h8000_0000);

    pend = '0;
    for (int i = 0; i < N; i++) begin
      pend = N'(1) << i;
      #1 chk($sformatf("R4 irq src %0d", i), 32'(irq), 1);
      claim($sformatf("R5 claim src %0d", i));
      chk($sformatf("R7 irq while active %0d", i), 32'(irq), 0);
      claim($sformatf("R6 empty claim %0d", i));
      wreg(A_DONE, 32'(i)); m_act[i] = 0;
      chk($sformatf("R7 re-present %0d", i), 32'(irq), 1);
      rreg(A_STAT, d); chk($sformatf("R8 status %0d", i), d, exp_stat());
      pend = '0;
    end

    pend = 16'h0100;
    wreg(A_DONE, 8); chk("R7 stray completion", 32'(irq), 1);
    wreg(A_CLREN, 8); m_en[8] = 0;
    chk("R11 clear enable drops irq", 32'(irq), 0);
    for (int i = 0; i < N; i++) begin wreg(A_CLREN, 32'(i)); m_en[i] = 0; end
    pend = '1;
    wreg(A_SETEN, 32'(N));
    chk("R3 out of range set ignored", 32'(irq), 0);
    wreg(A_SETEN, 5); m_en[5] = 1;
    rreg(A_STAT, d); chk("R3 set enable 5", d, 32'h8000_0005);

    p = 16'hACE1; q = 16'h1F3B;
    for (int k = 0; k < 30; k++) begin
      p = nxt(p); q = nxt(nxt(q));
      pend = '0;
      for (int i = 0; i < N; i++) begin
        wreg(q[i] ? A_SETEN : A_CLREN, 32'(i)); m_en[i] = q[i];
      end
      pend = p;
      for (int j = 0; j <= N; j++) begin
        rreg(A_STAT, d); chk($sformatf("R8 sweep %0d", k), d, exp_stat());
        if (cand() == 0) break;
        claim($sformatf("R5 sweep %0d", k));
      end
      claim($sformatf("R6 sweep %0d", k));
      for (int i = 0; i < N; i++)
        if (m_act[i]) begin wreg(A_DONE, 32'(i)); m_act[i] = 0; end
      chk($sformatf("R7 sweep release %0d", k), 32'(irq), 32'(cand() != 0));
    end

    for (int i = 0; i < N; i++) begin wreg(A_SETEN, 32'(i)); m_en[i] = 1; end
    pend = 16'h0006;
    claim("R5 pre concurrent");
    @(negedge clk);
    rd = 1; raddr = A_CLAIM; wr = 1; waddr = A_DONE; wdata = 1;
    @(negedge clk);
    rd = 0; wr = 0;
    chk("R10 concurrent claim value", rdata, 2);
    m_act = 16'h0004;
    rreg(A_STAT, d); chk("R10 status after concurrent", d, 32'h8000_0001);
    claim("R10 reclaim completed source");
    wreg(A_DONE, 1); wreg(A_DONE, 2); m_act = '0;

    @(negedge clk); wr = 1; waddr = A_SIG; wdata = 32'h0000_5A0F;
    @(posedge clk); #1;
    wr = 0;
    chk("R9 ipi valid", 32'(ipi_v), 1);
    chk("R9 ipi mask", 32'(ipi_m), 32'h5A);
    chk("R9 ipi id", 32'(ipi_id), 15);
    @(posedge clk); #1;
    chk("R9 ipi one cycle", 32'(ipi_v), 0);
    @(negedge clk); wr = 1; waddr = A_SIG; wdata = 32'h0000_0003;
    @(posedge clk); #1;
    wr = 0;
    chk("R9 zero mask no pulse", 32'(ipi_v), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule